// File: doc/BRIEF.md
# MDIO Management Controller

This block lets software reach the management registers of external Ethernet PHYs over a two-wire serial link. A small 32-bit register port holds two words. The command word carries a start flag, a direction flag, a PHY address, a PHY register number and the data to write. Writing the command word with the start flag set launches a Clause 22 frame on the serial clock and data pins. The start flag reads back as 1 while the frame is on the wire and clears itself when the frame ends. Software polls that flag. Once it reads 0, software fetches the outcome from the status word, which holds an error flag and the last 16 bits read from a PHY.

The serial clock comes from the system clock through a divider whose half period is a parameter. With the default of 10 cycles and a 50 MHz system clock, the serial clock runs at 2.5 MHz. The data output changes only while the serial clock falls, and input bits are sampled as it rises. Only PHY addresses up to a parameterised limit (default 2) are accepted. A command that names a higher address never reaches the wire and ends at once with the error flag set. During a read, a PHY that fails to pull the line low in the second turnaround bit is reported as an error, and the read data held from before is left in place.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command word reads 0 (start flag at bit 31 clear), the status word reads 0, `mdc` is low and `mdioOe` is low.
- R2: The command word sits at byte offset 0x14. Bit 31 is the start flag, bit 26 is 1 for a write and 0 for a read, bits 25:21 hold the PHY address, bits 20:16 hold the register number, bits 15:0 hold the write data, and bits 30:27 read as 0. A command written with bit 31 at 0 is stored and reads back, but no frame is started.
- R3: Writing the command word with bit 31 set starts a frame. Bit 31 reads 1 from the next cycle until the frame ends, and then clears without software action.
- R4: A write frame is 64 bits, sent MSB first: 32 ones, then 01, then 01, then the 5-bit PHY address, the 5-bit register number, 10, and the 16 data bits. `mdioOe` is high for all 64 bits.
- R5: A read frame uses opcode 10. `mdioOe` is high for the first 46 bits and low from the first turnaround bit to the end of the frame. The 16 bits sampled after the turnaround appear MSB first in status bits 15:0, and status bit 31 is 0.
- R6: `mdc` is low when idle. During a frame it is high for exactly MDC_HALF_CYCLES clocks and low for the same count, so one serial clock period is 2*MDC_HALF_CYCLES clocks. `mdioOut` never changes while `mdc` is high.
- R7: A command whose PHY address is above PHY_ADDR_MAX produces no `mdc` edges. Its start flag clears within two cycles, status bit 31 becomes 1, and status bits 15:0 keep their value.
- R8: If `mdioIn` is high when `mdc` rises in the second turnaround bit of a read, status bit 31 becomes 1 at the end of the frame and status bits 15:0 keep their previous value.
- R9: A write to the command word while its start flag is 1 is ignored. The readback and the frame on the wire both stay those of the running command.
- R10: The status word read at byte offset 0x10 during a frame returns the result of the previous transaction.
- R11: A completed write frame clears status bit 31 and leaves status bits 15:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte offset for register read and write |
| busWrEn | input | 1 | Register write strobe, one cycle |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data, combinational from busAddr |
| mdc | output | 1 | Serial management clock |
| mdioOut | output | 1 | Serial data driven toward the PHY |
| mdioOe | output | 1 | Output enable for mdioOut; low releases the line |
| mdioIn | input | 1 | Serial data as seen on the shared line |

## Verification
The main function is swept over every supported PHY address and every register number, first as reads of preset PHY contents and then as writes of a second pattern followed by reads. This separates errors in address and register placement from errors in data order, because each cell has its own value. Each frame is captured bit by bit at the rising serial clock and compared with a frame built arithmetically, and the output enable is checked for each bit. Error paths are driven on purpose: every unsupported address from 3 to 31, a PHY that leaves the turnaround high, a write that follows an error, and command writes and status reads made in the middle of a frame. Together these show which state each path may and may not touch.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_BITS     = 64;
  localparam int TA_FIRST_IDX   = 46;
  localparam int TA_SECOND_IDX  = 47;
  localparam int DATA_FIRST_IDX = 48;

  localparam logic [7:0] OFFS_STATUS = 8'h10;
  localparam logic [7:0] OFFS_CMD    = 8'h14;

  localparam int BIT_GO    = 31;
  localparam int BIT_WRITE = 26;
  localparam int BIT_ERR   = 31;

  // command word held in the datapath
  typedef struct packed {
    logic        go;
    logic        isWrite;
    logic [4:0]  phy;
    logic [4:0]  regNum;
    logic [15:0] wdata;
  } mdio_cmd_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic taCheck;
    logic finish;
    logic reject;
    logic drive;
  } mdio_strobe_t;

endpackage

// File: rtl/mdio_mgmt_seq.sv
module mdio_mgmt_seq
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF_CYCLES = 10,
  parameter int PHY_ADDR_MAX    = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdGo,
  input  logic         cmdWrite,
  input  logic [4:0]   cmdPhy,
  output logic         mdc,
  output mdio_strobe_t stb
);

  localparam int DIV_W = $clog2(MDC_HALF_CYCLES + 1);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(MDC_HALF_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_TA1   = IDX_W'(TA_FIRST_IDX);
  localparam logic [IDX_W-1:0] IDX_TA2   = IDX_W'(TA_SECOND_IDX);
  localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(DATA_FIRST_IDX);
  localparam logic [4:0]       PHY_LIMIT = 5'(PHY_ADDR_MAX);

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

  seq_state_t       state;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             mdcQ;
  logic             running;
  logic             divEnd;
  logic             riseTick;
  logic             fallTick;
  logic             phyOk;

  always_comb begin
    running  = (state == ST_RUN);
    divEnd   = (divCnt == DIV_LAST);
    riseTick = running && divEnd && !mdcQ;
    fallTick = running && divEnd && mdcQ;
    phyOk    = (cmdPhy <= PHY_LIMIT);

    stb.load    = !running && cmdGo && phyOk;
    stb.reject  = !running && cmdGo && !phyOk;
    stb.shift   = fallTick && (bitIdx != IDX_LAST);
    stb.finish  = fallTick && (bitIdx == IDX_LAST);
    stb.sample  = riseTick && !cmdWrite && (bitIdx >= IDX_DATA);
    stb.taCheck = riseTick && !cmdWrite && (bitIdx == IDX_TA2);
    stb.drive   = running && (cmdWrite || (bitIdx < IDX_TA1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitIdx <= '0;
      mdcQ   <= 1'b0;
    end else if (stb.load) begin
      state  <= ST_RUN;
      divCnt <= '0;
      bitIdx <= '0;
      mdcQ   <= 1'b0;
    end else if (running) begin
      if (divEnd) begin
        divCnt <= '0;
        mdcQ   <= !mdcQ;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      if (stb.shift)  bitIdx <= bitIdx + 1'b1;
      if (stb.finish) state  <= ST_IDLE;
    end
  end

  assign mdc = mdcQ;

endmodule

// File: rtl/mdio_mgmt_dp.sv
module mdio_mgmt_dp
  import mdio_mgmt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   busAddr,
  input  logic         busWrEn,
  input  logic [31:0]  busWrData,
  output logic [31:0]  busRdData,
  input  mdio_strobe_t stb,
  input  logic         mdioIn,
  output logic         mdioOut,
  output logic         mdioOe,
  output logic         cmdGo,
  output logic         cmdWrite,
  output logic [4:0]   cmdPhy
);

  mdio_cmd_t              cmdQ;
  logic [FRAME_BITS-1:0]  frameQ;
  logic [15:0]            rdShift;
  logic [15:0]            rdDataQ;
  logic                   errQ;
  logic                   taErrQ;
  logic                   cmdAccept;
  logic [3:0]             unusedRsvd;

  assign unusedRsvd = busWrData[30:27];

  function automatic logic [FRAME_BITS-1:0] buildFrame(input mdio_cmd_t c);
    logic [1:0] opBits;
    opBits = c.isWrite ? 2'b01 : 2'b10;
    return {32'hFFFF_FFFF, 2'b01, opBits, c.phy, c.regNum, 2'b10,
            c.isWrite ? c.wdata : 16'h0000};
  endfunction

  assign cmdAccept = busWrEn && (busAddr == OFFS_CMD) && !cmdQ.go;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ    <= '0;
      errQ    <= 1'b0;
      rdDataQ <= '0;
    end else if (stb.reject) begin
      cmdQ.go <= 1'b0;
      errQ    <= 1'b1;
    end else if (stb.finish) begin
      cmdQ.go <= 1'b0;
      if (cmdQ.isWrite) begin
        errQ <= 1'b0;
      end else if (taErrQ) begin
        errQ <= 1'b1;
      end else begin
        errQ    <= 1'b0;
        rdDataQ <= rdShift;
      end
    end else if (cmdAccept) begin
      cmdQ.go      <= busWrData[BIT_GO];
      cmdQ.isWrite <= busWrData[BIT_WRITE];
      cmdQ.phy     <= busWrData[25:21];
      cmdQ.regNum  <= busWrData[20:16];
      cmdQ.wdata   <= busWrData[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ  <= '0;
      rdShift <= '0;
      taErrQ  <= 1'b0;
    end else begin
      if (stb.load) begin
        frameQ <= buildFrame(cmdQ);
        taErrQ <= 1'b0;
      end else if (stb.shift) begin
        frameQ <= {frameQ[FRAME_BITS-2:0], 1'b0};
      end
      if (stb.sample)            rdShift <= {rdShift[14:0], mdioIn};
      if (stb.taCheck && mdioIn) taErrQ  <= 1'b1;
    end
  end

  always_comb begin
    case (busAddr)
      OFFS_CMD:    busRdData = {cmdQ.go, 4'b0000, cmdQ.isWrite, cmdQ.phy,
                                cmdQ.regNum, cmdQ.wdata};
      OFFS_STATUS: busRdData = {errQ, 15'h0000, rdDataQ};
      default:     busRdData = 32'h0000_0000;
    endcase
  end

  assign mdioOut  = frameQ[FRAME_BITS-1];
  assign mdioOe   = stb.drive;
  assign cmdGo    = cmdQ.go;
  assign cmdWrite = cmdQ.isWrite;
  assign cmdPhy   = cmdQ.phy;

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF_CYCLES = 10,
  parameter int PHY_ADDR_MAX    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  mdio_strobe_t stb;
  logic         cmdGo;
  logic         cmdWrite;
  logic [4:0]   cmdPhy;

  mdio_mgmt_seq #(
    .MDC_HALF_CYCLES(MDC_HALF_CYCLES),
    .PHY_ADDR_MAX   (PHY_ADDR_MAX)
  ) i_seq (
    .clk     (clk),
    .rstN    (rstN),
    .cmdGo   (cmdGo),
    .cmdWrite(cmdWrite),
    .cmdPhy  (cmdPhy),
    .mdc     (mdc),
    .stb     (stb)
  );

  mdio_mgmt_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .stb      (stb),
    .mdioIn   (mdioIn),
    .mdioOut  (mdioOut),
    .mdioOe   (mdioOe),
    .cmdGo    (cmdGo),
    .cmdWrite (cmdWrite),
    .cmdPhy   (cmdPhy)
  );

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
  parameter int MDC_HALF_CYCLES = 10,
  parameter int PHY_ADDR_MAX    = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       mdc,
  input logic       mdioOut,
  input logic       mdioOe,
  input logic       cmdGo,
  input logic       cmdWrite,
  input logic [4:0] cmdPhy
);

  logic        lastMdc;
  logic [31:0] highLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastMdc <= 1'b0;
      highLen <= '0;
    end else begin
      lastMdc <= mdc;
      highLen <= mdc ? (lastMdc ? highLen + 1 : 32'd1) : 32'd0;
    end
  end

  // R1 / R3: with no command pending the serial pins are quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cmdGo |-> (!mdc && !mdioOe));

  // R6: data never moves while the serial clock is high
  a_r6_out_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    mdc |-> $stable(mdioOut));

  // R6: each high phase lasts the configured half period
  a_r6_high_width: assert property (@(posedge clk) disable iff (!rstN)
    (!mdc && lastMdc) |-> (highLen == 32'(MDC_HALF_CYCLES)));

  // R7: an unsupported address never clocks the line
  a_r7_bad_phy_no_clock: assert property (@(posedge clk) disable iff (!rstN)
    (cmdGo && (cmdPhy > 5'(PHY_ADDR_MAX))) |-> !mdc);

  // R9: the running command cannot be altered
  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cmdGo && $past(cmdGo)) |-> $stable({cmdWrite, cmdPhy}));

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(
  .MDC_HALF_CYCLES(MDC_HALF_CYCLES),
  .PHY_ADDR_MAX   (PHY_ADDR_MAX)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .mdc     (mdc),
  .mdioOut (mdioOut),
  .mdioOe  (mdioOe),
  .cmdGo   (cmdGo),
  .cmdWrite(cmdWrite),
  .cmdPhy  (cmdPhy)
);

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  wire  [31:0] busRdData;
  wire         mdc;
  wire         mdioOut;
  wire         mdioOe;
  wire         mdioLine;

  logic phyDrv = 1'b0;
  logic phyBit = 1'b1;
  logic taFault = 1'b0;

  assign mdioLine = mdioOe ? mdioOut : (phyDrv ? phyBit : 1'b1);

  mdio_mgmt_ctrl #(.MDC_HALF_CYCLES(HALF), .PHY_ADDR_MAX(2)) i_mdio_mgmt_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioLine)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic finished = 1'b0;

  logic [15:0] phyMem [0:2][0:31];
  logic [15:0] expMem [0:2][0:31];
  logic [63:0] capFrame = '0;
  int          bitCnt = 0;
  logic [1:0]  frameOp = '0;
  logic [4:0]  framePhy = '0;
  logic [4:0]  frameReg = '0;
  logic        oeBad = 1'b0;
  int          riseCnt = 0;
  int          lastRiseCyc = 0;
  int          periodSeen = 0;

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      report();
    end
  end

  // PHY responder: captures at rising mdc, drives at falling mdc
  always @(posedge mdc) begin
    capFrame = {capFrame[62:0], mdioLine};
    if (bitCnt == 35) frameOp  = capFrame[1:0];
    if (bitCnt == 40) framePhy = capFrame[4:0];
    if (bitCnt == 45) frameReg = capFrame[4:0];
    if (mdioOe != ((bitCnt < 46) || (frameOp != 2'b10))) oeBad = 1'b1;
    if (bitCnt > 0) periodSeen = cyc - lastRiseCyc;
    lastRiseCyc = cyc;
    riseCnt++;
    bitCnt++;
    if (bitCnt == 64 && frameOp == 2'b01 && framePhy <= 5'd2)
      phyMem[framePhy][frameReg] = capFrame[15:0];
  end

  always @(negedge mdc) begin
    if (frameOp == 2'b10 && bitCnt >= 47 && bitCnt < 64 && framePhy <= 5'd2) begin
      phyDrv = !(bitCnt == 47 && taFault);
      phyBit = (bitCnt == 47) ? 1'b0 : phyMem[framePhy][frameReg][4'(63 - bitCnt)];
    end else begin
      phyDrv = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  function automatic logic [31:0] cmdWord(input bit go, input bit wr,
      input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    return {go, 4'b0000, wr, p, r, d};
  endfunction

  function automatic logic [63:0] expFrame(input bit wr, input logic [4:0] p,
      input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, p, r, 2'b10, d};
  endfunction

  task automatic startCmd(input bit wr, input logic [4:0] p, input logic [4:0] r,
                          input logic [15:0] d);
    bitCnt = 0; frameOp = '0; framePhy = '0; frameReg = '0; oeBad = 1'b0;
    busWr(8'h14, cmdWord(1'b1, wr, p, r, d));
  endtask

  task automatic waitDone(input string tag);
    logic [31:0] v;
    int n;
    n = 0;
    busRd(8'h14, v);
    while (v[31] && n < 5000) begin
      busRd(8'h14, v);
      n++;
    end
    if (v[31]) chk(1'b0, tag, 64'(v), 64'h0);
  endtask

  // full read with frame and result checks
  task automatic readCell(input int p, input int r, input bit doGoCheck);
    logic [31:0] v;
    logic [63:0] ef;
    startCmd(1'b0, 5'(p), 5'(r), 16'h0);
    if (doGoCheck) begin
      busRd(8'h14, v);
      chk(v == cmdWord(1'b1, 1'b0, 5'(p), 5'(r), 16'h0), "R3 go set during read",
          64'(v), 64'(cmdWord(1'b1, 1'b0, 5'(p), 5'(r), 16'h0)));
    end
    waitDone("R3 go clears");
    ef = expFrame(1'b0, 5'(p), 5'(r), 16'h0);
    chk(capFrame[63:18] == ef[63:18] && bitCnt == 64, "R5 read frame header",
        capFrame, ef);
    chk(!oeBad, "R5 read oe release", 64'(oeBad), 64'h0);
    busRd(8'h10, v);
    chk(v == {16'h0000, expMem[p][r]}, "R5 read result", 64'(v),
        64'({16'h0000, expMem[p][r]}));
  endtask

  task automatic writeCell(input int p, input int r, input logic [15:0] d);
    logic [63:0] ef;
    startCmd(1'b1, 5'(p), 5'(r), d);
    waitDone("R3 go clears write");
    expMem[p][r] = d;
    ef = expFrame(1'b1, 5'(p), 5'(r), d);
    chk(capFrame == ef && bitCnt == 64, "R4 write frame", capFrame, ef);
    chk(!oeBad, "R4 write oe held", 64'(oeBad), 64'h0);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] prevStatus;
    int riseBefore;

    for (int p = 0; p < 3; p++)
      for (int r = 0; r < 32; r++) begin
        phyMem[p][r] = 16'((p + 1) * 16'h1357 + r * 16'h0203);
        expMem[p][r] = phyMem[p][r];
      end

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRd(8'h14, v);
    chk(v == 32'h0, "R1 cmd after reset", 64'(v), 64'h0);
    busRd(8'h10, v);
    chk(v == 32'h0, "R1 status after reset", 64'(v), 64'h0);
    chk(mdc == 1'b0 && mdioOe == 1'b0, "R1 pins idle", 64'({mdc, mdioOe}), 64'h0);

    // R2 layout readback, no start when bit 31 is clear
    riseBefore = riseCnt;
    busWr(8'h14, 32'h7800_0000 | cmdWord(1'b0, 1'b1, 5'd2, 5'd19, 16'hBEEF));
    repeat (20) @(negedge clk);
    busRd(8'h14, v);
    chk(v == cmdWord(1'b0, 1'b1, 5'd2, 5'd19, 16'hBEEF), "R2 cmd readback",
        64'(v), 64'(cmdWord(1'b0, 1'b1, 5'd2, 5'd19, 16'hBEEF)));
    chk(riseCnt == riseBefore, "R2 no frame without go", 64'(riseCnt),
        64'(riseBefore));

    // R10 status during a read holds the previous result
    busRd(8'h10, prevStatus);
    startCmd(1'b0, 5'd1, 5'd7, 16'h0);
    repeat (40) @(negedge clk);
    busRd(8'h10, v);
    chk(v == prevStatus, "R10 status during frame", 64'(v), 64'(prevStatus));
    waitDone("R3 go clears");
    busRd(8'h10, v);
    chk(v == {16'h0, expMem[1][7]}, "R5 read result", 64'(v), 64'({16'h0, expMem[1][7]}));
    chk(periodSeen == 2 * HALF, "R6 mdc period", 64'(periodSeen), 64'(2 * HALF));
    chk(mdc == 1'b0, "R6 mdc idle low", 64'(mdc), 64'h0);

    // sweep: read every cell, write a new pattern, read back
    for (int p = 0; p < 3; p++)
      for (int r = 0; r < 32; r++) readCell(p, r, (r % 8) == 0);
    for (int p = 0; p < 3; p++)
      for (int r = 0; r < 32; r++)
        writeCell(p, r, 16'(16'hC0DE ^ (p * 16'h0F01) ^ (r * 16'h1111)));
    for (int p = 0; p < 3; p++)
      for (int r = 0; r < 32; r++) readCell(p, r, 1'b0);

    // R9 command write during a frame is ignored
    startCmd(1'b1, 5'd0, 5'd3, 16'h5A5A);
    repeat (10) @(negedge clk);
    busWr(8'h14, cmdWord(1'b1, 1'b0, 5'd2, 5'd9, 16'h1234));
    busRd(8'h14, v);
    chk(v == cmdWord(1'b1, 1'b1, 5'd0, 5'd3, 16'h5A5A), "R9 cmd unchanged",
        64'(v), 64'(cmdWord(1'b1, 1'b1, 5'd0, 5'd3, 16'h5A5A)));
    waitDone("R9 go clears");
    expMem[0][3] = 16'h5A5A;
    chk(capFrame == expFrame(1'b1, 5'd0, 5'd3, 16'h5A5A), "R9 frame of first cmd",
        capFrame, expFrame(1'b1, 5'd0, 5'd3, 16'h5A5A));
    readCell(0, 3, 1'b0);

    // R7 unsupported PHY addresses
    for (int p = 3; p < 32; p++) begin
      busRd(8'h10, prevStatus);
      riseBefore = riseCnt;
      startCmd(p[0], 5'(p), 5'(p), 16'hFFFF);
      @(negedge clk);
      busRd(8'h14, v);
      chk(v[31] == 1'b0, "R7 go cleared", 64'(v), 64'h0);
      busRd(8'h10, v);
      chk(v == {1'b1, 15'h0, prevStatus[15:0]}, "R7 error set data kept", 64'(v),
          64'({1'b1, 15'h0, prevStatus[15:0]}));
      chk(riseCnt == riseBefore, "R7 no mdc edges", 64'(riseCnt), 64'(riseBefore));
    end

    // recover with a good read, then R8 turnaround fault
    readCell(2, 30, 1'b0);
    busRd(8'h10, prevStatus);
    taFault = 1'b1;
    startCmd(1'b0, 5'd1, 5'd5, 16'h0);
    waitDone("R8 go clears");
    taFault = 1'b0;
    busRd(8'h10, v);
    chk(v == {1'b1, 15'h0, prevStatus[15:0]}, "R8 ta fault", 64'(v),
        64'({1'b1, 15'h0, prevStatus[15:0]}));

    // R11 write after error clears the flag, keeps data
    writeCell(1, 6, 16'h0F0F);
    busRd(8'h10, v);
    chk(v == {16'h0, prevStatus[15:0]}, "R11 write clears error", 64'(v),
        64'({16'h0, prevStatus[15:0]}));
    readCell(1, 6, 1'b0);

    finished = 1'b1;
    report();
  end

endmodule